// File: doc/BRIEF.md
# Store Buffer with Fence Drain

This block sits between a core's store pipeline and two write targets: a local RAM port and an external bus write port that returns write responses. The pipe hands a store over a valid/ready handshake. The block accepts it into a shared eight-entry buffer, and the pipe moves on without waiting for the write to land. Address bit `AW-1` picks the target: 1 means the external bus and 0 means local RAM. Each target has its own lane. Every lane drains in first-in order through its own valid/ready port, and the two lanes drain independently of each other. A store to one target can therefore leave before an older store to the other target.

A combinational lookup lets a load see its own core's buffered stores. It reports whether the given address is still held in the buffer and, if so, the data of the youngest store to that address. A store becomes visible to this lookup in the cycle after it is accepted.

Two fences order memory. A memory fence waits until the buffer is empty. An external fence also waits until every issued external write has been answered with a response pulse. While a fence waits, `st_ready` is low, so the pipe stalls. The external port stops issuing once a parameterised number of writes is awaiting a response.

Back-pressure rules:
- A store transfers on a clock edge where `st_valid` and `st_ready` are both high. `st_ready` is a combinational function of registered state and of `fence_req`.
- A target port holds its address and data steady while `valid` is high and `ready` is low.

Top module: `store_drain_buffer`

## Requirements
- R1: At most DEPTH (8) stores are held. With 8 held, `st_ready` is 0 and an offered store is not taken: the lookup does not report it.
- R2: When the buffer is not full and no fence is waiting or being requested, `st_ready` is 1 even while both target ports are stalled.
- R3: A store whose address bit AW-1 is 1 leaves on the external port, and any other store leaves on the RAM port. Each store leaves as one transfer carrying its full address and its full 32-bit data.
- R4: Within one target, stores leave in acceptance order. A port holds valid, address and data stable while it is stalled.
- R5: The two target lanes drain independently. External stores can all leave while an older RAM store is still waiting.
- R6: The lookup reports hit=1 with the youngest buffered data for an address that matches a buffered store, and hit=0 otherwise. Addresses that differ only in bit AW-1 are distinct.
- R7: A memory fence (`fence_ext`=0) keeps `fence_busy`=1 and `st_ready`=0 until the buffer is empty. It then pulses `fence_done` in the cycle after emptiness, whether or not any external responses are still outstanding.
- R8: An external fence (`fence_ext`=1) does not complete until the buffer is empty and no external write awaits its response. `fence_done` rises in the cycle after the last response is counted.
- R9: `fence_done` is high for exactly one cycle. A fence requested when its condition already holds completes in the cycle after the request.
- R10: After reset the buffer is empty, `st_ready`=1, both port valids are 0, `ld_hit`=0, and `fence_busy` and `fence_done` are 0.
- R11: While MAX_OUT (4) external writes await responses, `ext_valid` stays 0 and the store stays buffered. One response lets the next write issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered by the pipe |
| st_ready | output | 1 | Buffer can take the store |
| st_addr | input | AW | Store word address; bit AW-1 selects the external target |
| st_data | input | DW | Store data |
| ld_addr | input | AW | Lookup address for a load |
| ld_hit | output | 1 | A buffered store matches `ld_addr` |
| ld_data | output | DW | Youngest buffered data for `ld_addr` |
| ram_valid | output | 1 | RAM write offered |
| ram_ready | input | 1 | RAM accepts the write |
| ram_addr | output | AW | RAM write address |
| ram_data | output | DW | RAM write data |
| ext_valid | output | 1 | External write offered |
| ext_ready | input | 1 | External bus accepts the write |
| ext_addr | output | AW | External write address |
| ext_data | output | DW | External write data |
| ext_bresp | input | 1 | One write response per high cycle |
| fence_req | input | 1 | Fence request, sampled when no fence waits |
| fence_ext | input | 1 | Fence kind: 0 memory, 1 external |
| fence_busy | output | 1 | A fence is waiting; the pipe stalls |
| fence_done | output | 1 | One-cycle fence completion pulse |

## Verification
`st_ready` and the lookup outputs are combinational and are due in the same cycle as their inputs. The bench drives inputs at the falling edge and checks these outputs a moment later. A store is visible to the lookup, and counted toward full, one rising edge after acceptance. A port pop happens at every rising edge with valid and ready high. `fence_done` rises one edge after the completion condition first holds. The bench therefore counts the edges from the release of `ram_ready`, or from the last response, to the pulse, and checks the pulse's exact cycle and its one-cycle width.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic {FENCE_MEM = 1'b0, FENCE_EXT = 1'b1} fence_kind_e;
  typedef enum logic {FS_IDLE = 1'b0, FS_WAIT = 1'b1} fence_state_e;
  localparam int NUM_LANES = 2;
  localparam int LANE_RAM  = 0;
  localparam int LANE_EXT  = 1;
endpackage

// File: rtl/sb_lane.sv
module sb_lane #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [AW-1:0]                push_addr,
  input  logic [DW-1:0]                push_data,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [AW-1:0]                out_addr,
  output logic [DW-1:0]                out_data,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  input  logic [AW-1:0]                look_addr,
  output logic                         look_hit,
  output logic [DW-1:0]                look_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] DEPTH_V = CW'(DEPTH);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic          pop;

  assign out_valid = (cnt_q != '0);
  assign out_addr  = addr_q[rd_ptr];
  assign out_data  = data_q[rd_ptr];
  assign pop       = out_valid && out_ready;
  assign count     = cnt_q;

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr] <= push_addr;
      data_q[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // Walk oldest to youngest so the youngest match wins.
  always_comb begin
    look_hit  = 1'b0;
    look_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [PW-1:0] idx;
      idx = rd_ptr + PW'(i);
      if ((CW'(i) < cnt_q) && (addr_q[idx] == look_addr)) begin
        look_hit  = 1'b1;
        look_data = data_q[idx];
      end
    end
  end

  assert_push_room_R1: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < DEPTH_V));

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data)));
endmodule

// File: rtl/sb_resp_track.sv
module sb_resp_track #(
  parameter int MAX_OUT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic resp,
  output logic at_limit,
  output logic none_out
);
  localparam int CW = $clog2(MAX_OUT+1);
  localparam logic [CW-1:0] MAX_V = CW'(MAX_OUT);

  logic [CW-1:0] cnt_q;

  assign at_limit = (cnt_q == MAX_V);
  assign none_out = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else begin
      case ({issue, resp})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_limit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (cnt_q < MAX_V));
endmodule

// File: rtl/sb_fence_ctl.sv
module sb_fence_ctl
  import sb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic kind_ext,
  input  logic buf_empty,
  input  logic resp_idle,
  output logic busy,
  output logic done
);
  fence_state_e state_q;
  fence_kind_e  kind_q;
  logic         met_now, met_wait;

  assign met_now  = buf_empty && (!kind_ext || resp_idle);
  assign met_wait = buf_empty && ((kind_q == FENCE_MEM) || resp_idle);
  assign busy     = (state_q == FS_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      kind_q  <= FENCE_MEM;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        FS_IDLE: if (req) begin
          kind_q <= kind_ext ? FENCE_EXT : FENCE_MEM;
          if (met_now) done <= 1'b1;
          else         state_q <= FS_WAIT;
        end
        FS_WAIT: if (met_wait) begin
          done    <= 1'b1;
          state_q <= FS_IDLE;
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  assert_done_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> buf_empty);

  assert_done_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (kind_q == FENCE_EXT)) |-> resp_idle);
endmodule

// File: rtl/store_drain_buffer.sv
module store_drain_buffer
  import sb_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int MAX_OUT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  output logic          ram_valid,
  input  logic          ram_ready,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_data,
  output logic          ext_valid,
  input  logic          ext_ready,
  output logic [AW-1:0] ext_addr,
  output logic [DW-1:0] ext_data,
  input  logic          ext_bresp,
  input  logic          fence_req,
  input  logic          fence_ext,
  output logic          fence_busy,
  output logic          fence_done
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW:0] DEPTH_V = (CW+1)'(DEPTH);

  logic          lane_push  [NUM_LANES];
  logic          lane_ovld  [NUM_LANES];
  logic          lane_ordy  [NUM_LANES];
  logic [AW-1:0] lane_oaddr [NUM_LANES];
  logic [DW-1:0] lane_odata [NUM_LANES];
  logic [CW-1:0] lane_cnt   [NUM_LANES];
  logic          lane_hit   [NUM_LANES];
  logic [DW-1:0] lane_ldata [NUM_LANES];

  logic          accept, to_ext, at_limit, none_out, ext_issue, buf_empty;
  logic [CW:0]   total;

  assign to_ext    = st_addr[AW-1];
  assign total     = {1'b0, lane_cnt[LANE_RAM]} + {1'b0, lane_cnt[LANE_EXT]};
  assign buf_empty = (total == '0);
  assign st_ready  = (total < DEPTH_V) && !fence_busy && !fence_req;
  assign accept    = st_valid && st_ready;

  assign lane_push[LANE_RAM] = accept && !to_ext;
  assign lane_push[LANE_EXT] = accept && to_ext;
  assign lane_ordy[LANE_RAM] = ram_ready;
  assign lane_ordy[LANE_EXT] = ext_ready && !at_limit;

  generate
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      sb_lane #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (lane_push[g]),
        .push_addr (st_addr),
        .push_data (st_data),
        .out_valid (lane_ovld[g]),
        .out_ready (lane_ordy[g]),
        .out_addr  (lane_oaddr[g]),
        .out_data  (lane_odata[g]),
        .count     (lane_cnt[g]),
        .look_addr (ld_addr),
        .look_hit  (lane_hit[g]),
        .look_data (lane_ldata[g])
      );
    end
  endgenerate

  assign ram_valid = lane_ovld[LANE_RAM];
  assign ram_addr  = lane_oaddr[LANE_RAM];
  assign ram_data  = lane_odata[LANE_RAM];

  assign ext_valid = lane_ovld[LANE_EXT] && !at_limit;
  assign ext_addr  = lane_oaddr[LANE_EXT];
  assign ext_data  = lane_odata[LANE_EXT];
  assign ext_issue = ext_valid && ext_ready;

  assign ld_hit  = ld_addr[AW-1] ? lane_hit[LANE_EXT]   : lane_hit[LANE_RAM];
  assign ld_data = ld_addr[AW-1] ? lane_ldata[LANE_EXT] : lane_ldata[LANE_RAM];

  sb_resp_track #(.MAX_OUT(MAX_OUT)) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (ext_issue),
    .resp     (ext_bresp),
    .at_limit (at_limit),
    .none_out (none_out)
  );

  sb_fence_ctl u_fence (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (fence_req),
    .kind_ext  (fence_ext),
    .buf_empty (buf_empty),
    .resp_idle (none_out),
    .busy      (fence_busy),
    .done      (fence_done)
  );

  assert_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_valid |-> !ram_addr[AW-1]) and (ext_valid |-> ext_addr[AW-1]));
endmodule

// File: tb/sim_store_drain_buffer.sv
module sim_store_drain_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 1'b0, st_ready;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [AW-1:0] ld_addr = '0;
  logic ld_hit;
  logic [DW-1:0] ld_data;
  logic ram_valid, ram_ready = 1'b0;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_data;
  logic ext_valid, ext_ready = 1'b0;
  logic [AW-1:0] ext_addr;
  logic [DW-1:0] ext_data;
  logic ext_bresp = 1'b0;
  logic fence_req = 1'b0, fence_ext = 1'b0;
  logic fence_busy, fence_done;

  int checks = 0;
  int errors = 0;
  int ram_n = 0;
  int ext_n = 0;
  logic [AW-1:0] ram_la [32];
  logic [DW-1:0] ram_ld [32];
  logic [DW-1:0] ext_ld [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  store_drain_buffer u0 (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
    .ram_valid(ram_valid), .ram_ready(ram_ready), .ram_addr(ram_addr), .ram_data(ram_data),
    .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_addr(ext_addr), .ext_data(ext_data),
    .ext_bresp(ext_bresp), .fence_req(fence_req), .fence_ext(fence_ext),
    .fence_busy(fence_busy), .fence_done(fence_done)
  );

  // Target models: log every transfer seen at a rising edge.
  always @(posedge clk) begin
    if (ram_valid && ram_ready && ram_n < 32) begin
      ram_la[ram_n] = ram_addr;
      ram_ld[ram_n] = ram_data;
      ram_n++;
    end
    if (ext_valid && ext_ready && ext_n < 32) begin
      ext_ld[ext_n] = ext_data;
      ext_n++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    st_valid = 1'b1; st_addr = a; st_data = d;
    #1 chk(req, 32'(st_ready), 32'd1);
    @(posedge clk); @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic do_load(input logic [AW-1:0] a, input logic h, input logic [DW-1:0] d, input string req);
    ld_addr = a;
    #1 chk(req, 32'(ld_hit), 32'(h));
    if (h) chk(req, ld_data, d);
  endtask

  // {op(1: load), addr, data, hit}; target ports stalled throughout.
  localparam logic [49:0] VEC [13] = '{
    {1'b0, 16'h0010, 32'h11111111, 1'b0},
    {1'b0, 16'h8020, 32'h22222222, 1'b0},
    {1'b0, 16'h0010, 32'h33333333, 1'b0},
    {1'b0, 16'h0030, 32'h44444444, 1'b0},
    {1'b0, 16'h8020, 32'h55555555, 1'b0},
    {1'b1, 16'h0010, 32'h33333333, 1'b1},
    {1'b1, 16'h8020, 32'h55555555, 1'b1},
    {1'b1, 16'h0030, 32'h44444444, 1'b1},
    {1'b1, 16'h0040, 32'h00000000, 1'b0},
    {1'b1, 16'h8010, 32'h00000000, 1'b0},
    {1'b0, 16'h0050, 32'h66666666, 1'b0},
    {1'b0, 16'h8060, 32'h77777777, 1'b0},
    {1'b0, 16'h0070, 32'h88888888, 1'b0}
  };

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R10 st_ready", 32'(st_ready), 32'd1);
    chk("R10 ram_valid", 32'(ram_valid), 32'd0);
    chk("R10 ext_valid", 32'(ext_valid), 32'd0);
    chk("R10 ld_hit", 32'(ld_hit), 32'd0);
    chk("R10 fence", {30'd0, fence_busy, fence_done}, 32'd0);

    // Vector table: R2 stores while stalled, R6 forwarding lookups.
    for (int i = 0; i < 13; i++) begin
      if (VEC[i][49]) begin
        do_load(VEC[i][48:33], VEC[i][0], VEC[i][32:1], "R6 lookup");
        @(negedge clk);
      end else begin
        do_store(VEC[i][48:33], VEC[i][32:1], "R2 accept");
      end
    end
    do_load(16'h0070, 1'b1, 32'h88888888, "R6 newest");

    // Full: R1.
    st_valid = 1'b1; st_addr = 16'h0090; st_data = 32'h99999999;
    #1 chk("R1 full st_ready", 32'(st_ready), 32'd0);
    @(posedge clk); @(negedge clk);
    st_valid = 1'b0;
    do_load(16'h0090, 1'b0, 32'h0, "R1 refused store");
    chk("R3 ram head addr", 32'(ram_addr), 32'h0010);
    chk("R3 ram head data", ram_data, 32'h11111111);
    chk("R3 ext head addr", 32'(ext_addr), 32'h8020);

    // External lane drains alone: R4, R5.
    ext_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) ext_ready = 1'b0;
    #1;
    chk("R5 ext count", 32'(ext_n), 32'd3);
    chk("R5 ram untouched", 32'(ram_n), 32'd0);
    chk("R4 ext order0", ext_ld[0], 32'h22222222);
    chk("R4 ext order1", ext_ld[1], 32'h55555555);
    chk("R4 ext order2", ext_ld[2], 32'h77777777);
    chk("R4 ram hold valid", 32'(ram_valid), 32'd1);
    chk("R4 ram hold data", ram_data, 32'h11111111);
    chk("R5 ext empty", 32'(ext_valid), 32'd0);

    // Memory fence: R7.
    fence_req = 1'b1; fence_ext = 1'b0;
    @(posedge clk); @(negedge clk);
    fence_req = 1'b0;
    st_valid = 1'b1; st_addr = 16'h00A0; st_data = 32'hAAAA0000;
    #1;
    chk("R7 busy", 32'(fence_busy), 32'd1);
    chk("R7 stall", 32'(st_ready), 32'd0);
    chk("R7 not done", 32'(fence_done), 32'd0);
    @(posedge clk); @(negedge clk);
    st_valid = 1'b0;
    ram_ready = 1'b1;
    k = 0;
    while (k < 20) begin
      @(negedge clk);
      k++;
      if (fence_done) break;
    end
    chk("R7 done cycle", 32'(k), 32'd6);
    ram_ready = 1'b0;
    chk("R7 ram count", 32'(ram_n), 32'd5);
    chk("R4 ram a0", 32'(ram_la[0]), 32'h0010);
    chk("R4 ram d1", ram_ld[1], 32'h33333333);
    chk("R4 ram d2", ram_ld[2], 32'h44444444);
    chk("R4 ram d3", ram_ld[3], 32'h66666666);
    chk("R3 ram a4", 32'(ram_la[4]), 32'h0070);
    do_load(16'h00A0, 1'b0, 32'h0, "R7 stalled store");
    @(negedge clk);
    chk("R9 one cycle", 32'(fence_done), 32'd0);

    // External fence with 3 responses outstanding: R8.
    fence_req = 1'b1; fence_ext = 1'b1;
    @(posedge clk); @(negedge clk);
    fence_req = 1'b0;
    #1;
    chk("R8 waits resp", 32'(fence_done), 32'd0);
    chk("R8 busy", 32'(fence_busy), 32'd1);
    ext_bresp = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) ext_bresp = 1'b0;
    chk("R8 not early", 32'(fence_done), 32'd0);
    @(negedge clk);
    chk("R8 done", 32'(fence_done), 32'd1);
    @(negedge clk);
    chk("R9 pulse width", 32'(fence_done), 32'd0);
    chk("R9 idle", 32'(fence_busy), 32'd0);

    // Fence on an already drained block: R9.
    fence_req = 1'b1; fence_ext = 1'b1;
    @(posedge clk); @(negedge clk);
    fence_req = 1'b0;
    chk("R9 immediate", 32'(fence_done), 32'd1);
    @(negedge clk);
    chk("R9 immediate width", 32'(fence_done), 32'd0);

    // Outstanding limit: R11.
    ext_ready = 1'b1;
    for (int i = 0; i < 5; i++) do_store(16'h8100 + 16'(i), 32'hA0 + 32'(i), "R11 accept");
    repeat (3) @(negedge clk);
    #1;
    chk("R11 held", 32'(ext_valid), 32'd0);
    chk("R11 issued", 32'(ext_n), 32'd7);
    do_load(16'h8104, 1'b1, 32'hA4, "R11 still buffered");
    ext_bresp = 1'b1;
    @(posedge clk); @(negedge clk);
    ext_bresp = 1'b0;
    #1 chk("R11 resumes", 32'(ext_valid), 32'd1);
    @(negedge clk);
    chk("R11 drained", 32'(ext_valid), 32'd0);
    chk("R11 issued last", 32'(ext_n), 32'd8);
    chk("R3 ext data", ext_ld[7], 32'hA4);
    do_load(16'h8104, 1'b0, 32'h0, "R11 left buffer");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule